// File: doc/BRIEF.md
# Secondary Interrupt Controller with Passthrough

This block collects 32 level-sensitive interrupt requests and presents them to a primary interrupt controller in two ways. All inputs are gated by a software-programmed enable mask and OR-reduced onto one summary line, output line 31. In addition, each input in the range 21 to 30 can be routed straight to the primary-controller line with the same number. This bypass is controlled by its own enable register and ignores the summary mask. Output lines 0 to 20 are never driven high.

Software reaches the block through a single-cycle APB-style register bus in a 4 KB window. The word index is the byte address divided by four. Through the bus it reads the masked and raw request state. It changes the enable mask and the bypass enable through separate set and clear writes, so no read-modify-write is needed. A software interrupt control works on bit 0 of the enable mask. The outputs are registered: an input change, or a register write, shows on the output lines one clock later.

Top module: `irq_fanin_ctrl`

## Requirements
- R1: After synchronous reset, all 32 output lines, the enable mask, the bypass enable, the raw level register and `prdata` are zero.
- R2: The raw level register takes the value of `irq_in` on every clock edge. A read of word index 1 returns it.
- R3: Output line 31 is high exactly when raw level AND enable mask is nonzero. A read of word index 0 returns raw level AND enable mask.
- R4: A write to word index 2 ORs the written value into the enable mask. A write to word index 3 clears the enable bits that are 1 in the written value. A read of word index 2 returns the mask.
- R5: For each line n from 21 to 30, output n equals raw level bit n while bypass enable bit n is set, whatever the enable mask holds. Output n is 0 while that bit is clear. Lines 0 to 20 are always 0.
- R6: A write to word index 8 ORs (value AND 0x7FE00000) into the bypass enable, so only bits 21 to 30 can ever be set. A write to word index 9 clears the bypass bits that are 1 in the value. A read of word index 8 returns the bypass enable.
- R7: A read of word index 4 returns raw level bit 0 in bit 0, with all other bits 0. A write to index 4 with a nonzero value sets enable bit 0 only. A write to index 5 with a nonzero value clears enable bit 0 only. A zero value written to index 4 or 5 changes nothing.
- R8: Reads of word indices 3, 5, 6, 7, 9 and 10 to 1023 return 0. Writes to indices 0, 1, 6, 7 and 10 to 1023 change no register and no output.
- R9: A read is a setup cycle (`psel`=1, `penable`=0, `pwrite`=0) followed by an access cycle. `prdata` is registered at the end of the setup cycle and holds the value in the access cycle. A write takes effect at the end of its access cycle (`psel`=`penable`=`pwrite`=1). The output lines reflect an input change or a register write from the next clock edge on, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address within the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| irq_in | input | 32 | Level-sensitive interrupt requests |
| irq_out | output | 32 | Line 31 is the masked summary, lines 21 to 30 are the bypass, lines 0 to 20 are low |

## Verification
On every cycle the assertions check that the summary line and the bypass lines agree with the stored level, mask and bypass registers. They also check that bypass bits outside 21 to 30 never appear, that the level register follows the inputs with one cycle of delay, and that enable and bypass set writes merge as specified. Only the bench scenarios show the register-level behaviour that needs a read back after a write. That covers the software-interrupt rule that a zero write does nothing, the silence of unmapped indices and the reset contents. The bench also shows that an output holds its old value until the clock edge after an input change.

// File: rtl/irq_fanin_pkg.sv
package irq_fanin_pkg;

    localparam int NUM_IRQ   = 32;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int IDX_W     = ADDR_W - 2;
    localparam int PT_LO     = 21;
    localparam int PT_HI     = 30;
    localparam int PT_W      = PT_HI - PT_LO + 1;
    localparam int COMB_LINE = 31;

    typedef enum logic [IDX_W-1:0] {
        IDX_STATUS = 10'd0,
        IDX_RAW    = 10'd1,
        IDX_EN_SET = 10'd2,
        IDX_EN_CLR = 10'd3,
        IDX_SW_SET = 10'd4,
        IDX_SW_CLR = 10'd5,
        IDX_PT_SET = 10'd8,
        IDX_PT_CLR = 10'd9
    } reg_idx_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Bits that the bypass enable may hold
    function automatic logic [NUM_IRQ-1:0] pt_field_mask();
        logic [NUM_IRQ-1:0] m;
        m = '0;
        for (int i = PT_LO; i <= PT_HI; i++) begin
            m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_fanin_bus.sv
module irq_fanin_bus
    import irq_fanin_pkg::*;
(
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output bus_req_t          req
);

    always_comb begin
        req.rd    = psel & ~penable & ~pwrite;
        req.wr    = psel & penable & pwrite;
        req.idx   = IDX_W'(paddr >> 2);
        req.wdata = pwdata;
    end

endmodule

// File: rtl/irq_fanin_regs.sv
module irq_fanin_regs
    import irq_fanin_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           req,
    input  logic [NUM_IRQ-1:0] irq_in,
    output logic [DATA_W-1:0]  prdata,
    output logic [NUM_IRQ-1:0] en_q,
    output logic [NUM_IRQ-1:0] pt_q,
    output logic [NUM_IRQ-1:0] lvl_q,
    output logic [NUM_IRQ-1:0] en_nxt,
    output logic [PT_W-1:0]    pt_nxt_f
);

    localparam logic [NUM_IRQ-1:0] PT_MASK = pt_field_mask();

    logic [NUM_IRQ-1:0] pt_nxt;
    logic [DATA_W-1:0]  rd_val;
    logic               wr_nonzero;

    assign wr_nonzero = |req.wdata;

    always_comb begin
        en_nxt = en_q;
        pt_nxt = pt_q;
        if (req.wr) begin
            case (req.idx)
                IDX_EN_SET: en_nxt = en_q | req.wdata;
                IDX_EN_CLR: en_nxt = en_q & ~req.wdata;
                IDX_SW_SET: if (wr_nonzero) en_nxt[0] = 1'b1;
                IDX_SW_CLR: if (wr_nonzero) en_nxt[0] = 1'b0;
                IDX_PT_SET: pt_nxt = pt_q | (req.wdata & PT_MASK);
                IDX_PT_CLR: pt_nxt = pt_q & ~req.wdata;
                default: ;
            endcase
        end
    end

    assign pt_nxt_f = pt_nxt[PT_HI:PT_LO];

    always_comb begin
        case (req.idx)
            IDX_STATUS: rd_val = lvl_q & en_q;
            IDX_RAW:    rd_val = lvl_q;
            IDX_EN_SET: rd_val = en_q;
            IDX_SW_SET: rd_val = {{(DATA_W-1){1'b0}}, lvl_q[0]};
            IDX_PT_SET: rd_val = pt_q;
            default:    rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pt_q   <= '0;
            lvl_q  <= '0;
            prdata <= '0;
        end else begin
            en_q  <= en_nxt;
            pt_q  <= pt_nxt;
            lvl_q <= irq_in;
            if (req.rd) begin
                prdata <= rd_val;
            end
        end
    end

endmodule

// File: rtl/irq_fanin_route.sv
module irq_fanin_route
    import irq_fanin_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] lvl_nxt,
    input  logic [NUM_IRQ-1:0] en_nxt,
    input  logic [PT_W-1:0]    pt_nxt,
    output logic [NUM_IRQ-1:0] irq_out
);

    logic [NUM_IRQ-1:0] out_d;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        if (i >= PT_LO && i <= PT_HI) begin : g_bypass
            assign out_d[i] = lvl_nxt[i] & pt_nxt[i-PT_LO];
        end else if (i == COMB_LINE) begin : g_summary
            assign out_d[i] = |(lvl_nxt & en_nxt);
        end else begin : g_tied
            assign out_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_out <= '0;
        end else begin
            irq_out <= out_d;
        end
    end

endmodule

// File: rtl/irq_fanin_ctrl.sv
module irq_fanin_ctrl
    import irq_fanin_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [DATA_W-1:0]  pwdata,
    output logic [DATA_W-1:0]  prdata,
    input  logic [NUM_IRQ-1:0] irq_in,
    output logic [NUM_IRQ-1:0] irq_out
);

    bus_req_t           req;
    logic [NUM_IRQ-1:0] en_q;
    logic [NUM_IRQ-1:0] pt_q;
    logic [NUM_IRQ-1:0] lvl_q;
    logic [NUM_IRQ-1:0] en_nxt;
    logic [PT_W-1:0]    pt_nxt_f;

    irq_fanin_bus u_bus (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .req     (req)
    );

    irq_fanin_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .irq_in   (irq_in),
        .prdata   (prdata),
        .en_q     (en_q),
        .pt_q     (pt_q),
        .lvl_q    (lvl_q),
        .en_nxt   (en_nxt),
        .pt_nxt_f (pt_nxt_f)
    );

    irq_fanin_route u_route (
        .clk     (clk),
        .rst     (rst),
        .lvl_nxt (irq_in),
        .en_nxt  (en_nxt),
        .pt_nxt  (pt_nxt_f),
        .irq_out (irq_out)
    );

endmodule

// File: rtl/irq_fanin_chk.sv
module irq_fanin_chk
    import irq_fanin_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic [ADDR_W-1:0]  paddr,
    input logic [DATA_W-1:0]  pwdata,
    input logic [DATA_W-1:0]  prdata,
    input logic [NUM_IRQ-1:0] irq_in,
    input logic [NUM_IRQ-1:0] irq_out,
    input logic [NUM_IRQ-1:0] en_q,
    input logic [NUM_IRQ-1:0] pt_q,
    input logic [NUM_IRQ-1:0] lvl_q
);

    localparam logic [NUM_IRQ-1:0] PT_MASK = pt_field_mask();

    logic             wr_acc;
    logic             rd_setup;
    logic [IDX_W-1:0] widx;

    assign wr_acc   = psel && penable && pwrite;
    assign rd_setup = psel && !penable && !pwrite;
    assign widx     = paddr[ADDR_W-1:2];

    AST_SUMMARY_LINE: assert property (@(posedge clk) disable iff (rst)
        irq_out[COMB_LINE] == |(lvl_q & en_q)); // R3

    AST_BYPASS_LINES: assert property (@(posedge clk) disable iff (rst)
        irq_out[PT_HI:PT_LO] == (lvl_q[PT_HI:PT_LO] & pt_q[PT_HI:PT_LO])); // R5

    AST_LOW_LINES_QUIET: assert property (@(posedge clk) disable iff (rst)
        irq_out[PT_LO-1:0] == '0); // R5

    AST_LEVEL_TRACKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        !rst |=> lvl_q == $past(irq_in)); // R2

    AST_BYPASS_FIELD_ONLY: assert property (@(posedge clk) disable iff (rst)
        (pt_q & ~PT_MASK) == '0); // R6

    AST_ENABLE_SET_MERGE: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && widx == IDX_W'(2)) |=> en_q == ($past(en_q) | $past(pwdata))); // R4

    AST_ENABLE_CLR_MERGE: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && widx == IDX_W'(3)) |=> en_q == ($past(en_q) & ~$past(pwdata))); // R4

    AST_BYPASS_SET_MERGE: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && widx == IDX_W'(8)) |=> pt_q == ($past(pt_q) | ($past(pwdata) & PT_MASK))); // R6

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_setup && widx > IDX_W'(9)) |=> prdata == '0); // R8

    AST_ENABLE_HELD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !wr_acc |=> $stable(en_q)); // R9

endmodule

bind irq_fanin_ctrl irq_fanin_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .irq_in  (irq_in),
    .irq_out (irq_out),
    .en_q    (en_q),
    .pt_q    (pt_q),
    .lvl_q   (lvl_q)
);

// File: tb/irq_fanin_ctrl_test.sv
`timescale 1ns/1ps
module irq_fanin_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [31:0] irq_in = '0;
    logic [31:0] irq_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    irq_fanin_ctrl uut (
        .clk     (clk),
        .rst     (rst),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .irq_in  (irq_in),
        .irq_out (irq_out)
    );

    localparam int NV = 6;
    localparam logic [31:0] V_IN [NV] = '{32'h0000_0001, 32'h0000_0F00, 32'h4020_0000,
                                         32'hFFFF_FFFF, 32'h0200_0000, 32'h1234_5678};
    localparam logic [31:0] V_EN [NV] = '{32'h0000_0001, 32'h0000_00FF, 32'h0000_0000,
                                         32'h8000_0000, 32'h0200_0000, 32'hFFFF_FFFF};
    localparam logic [31:0] V_PT [NV] = '{32'h0000_0000, 32'h0000_0000, 32'h4020_0000,
                                         32'h7FE0_0000, 32'h0000_0000, 32'hFFFF_FFFF};

    function automatic logic [31:0] expect_out(logic [31:0] lvl, logic [31:0] en, logic [31:0] pt);
        logic [31:0] r;
        r = lvl & pt & 32'h7FE0_0000;
        r[31] = |(lvl & en);
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input int idx, input logic [31:0] val);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1;
        paddr = 12'(idx * 4); pwdata = val;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(input int idx, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0;
        paddr = 12'(idx * 4);
        @(negedge clk);
        penable = 1'b1;
        d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got %08h expected %08h", 32'h0, 32'h1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] hold;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset contents
        check("R1 irq_out after reset", irq_out, 32'h0);
        check("R1 prdata after reset", prdata, 32'h0);
        bus_read(0, d); check("R1 status after reset", d, 32'h0);
        bus_read(2, d); check("R1 enable after reset", d, 32'h0);
        bus_read(8, d); check("R1 bypass after reset", d, 32'h0);

        // Vector table: R2, R3, R5, R6
        for (int v = 0; v < NV; v++) begin
            bus_write(3, 32'hFFFF_FFFF);
            bus_write(9, 32'hFFFF_FFFF);
            irq_in = V_IN[v];
            bus_write(2, V_EN[v]);
            bus_write(8, V_PT[v]);
            check($sformatf("R3 R5 vector %0d irq_out", v), irq_out,
                  expect_out(V_IN[v], V_EN[v], V_PT[v]));
            bus_read(0, d);
            check($sformatf("R3 vector %0d status", v), d, V_IN[v] & V_EN[v]);
            bus_read(1, d);
            check($sformatf("R2 vector %0d raw", v), d, V_IN[v]);
        end

        // R6: set masks to bits 21..30, clear removes selected bits
        bus_read(8, d); check("R6 bypass set masked", d, 32'h7FE0_0000);
        bus_write(9, 32'h0040_0000);
        bus_read(8, d); check("R6 bypass clear", d, 32'h7FA0_0000);

        // R4: enable set/clear merge
        bus_write(3, 32'hFFFF_FFFF);
        bus_write(2, 32'h0000_00F0);
        bus_write(2, 32'h0000_0F00);
        bus_read(2, d); check("R4 enable set merges", d, 32'h0000_0FF0);
        bus_write(3, 32'h0000_0330);
        bus_read(2, d); check("R4 enable clear", d, 32'h0000_0CC0);

        // R5: bypass independent of enable mask
        bus_write(3, 32'hFFFF_FFFF);
        bus_write(9, 32'hFFFF_FFFF);
        bus_write(8, 32'h0200_0000);
        irq_in = 32'h0200_0000;
        @(negedge clk);
        check("R5 bypass with mask clear", irq_out, 32'h0200_0000);
        bus_write(9, 32'h0200_0000);
        check("R5 bypass cleared drives low", irq_out, 32'h0);

        // R7: software interrupt
        bus_write(3, 32'hFFFF_FFFF);
        irq_in = 32'h0000_0003;
        @(negedge clk);
        bus_read(4, d); check("R7 soft read bit0 only", d, 32'h1);
        bus_write(4, 32'h0);
        bus_read(2, d); check("R7 zero soft set ignored", d, 32'h0);
        bus_write(4, 32'h0000_0100);
        bus_read(2, d); check("R7 soft set bit0 only", d, 32'h1);
        check("R7 summary from soft enable", irq_out, 32'h8000_0000);
        bus_write(5, 32'h0);
        bus_read(2, d); check("R7 zero soft clear ignored", d, 32'h1);
        bus_write(5, 32'h0000_0010);
        bus_read(2, d); check("R7 soft clear", d, 32'h0);

        // R9: output latency on input change and on writes
        bus_write(2, 32'h0000_0001);
        irq_in = 32'h0;
        @(negedge clk);
        check("R9 summary low after input drop", irq_out, 32'h0);
        irq_in = 32'h0000_0001;
        #1;
        check("R9 output holds before edge", irq_out, 32'h0);
        @(negedge clk);
        check("R9 output after edge", irq_out, 32'h8000_0000);
        bus_write(3, 32'h0000_0001);
        check("R9 write effect next edge", irq_out, 32'h0);

        // R8: unmapped indices
        bus_write(2, 32'h0000_0005);
        bus_write(8, 32'h0080_0000);
        irq_in = 32'h0080_0005;
        @(negedge clk);
        hold = irq_out;
        check("R8 baseline outputs", hold, 32'h8080_0000);
        bus_read(3, d);    check("R8 read idx3", d, 32'h0);
        bus_read(5, d);    check("R8 read idx5", d, 32'h0);
        bus_read(6, d);    check("R8 read idx6", d, 32'h0);
        bus_read(9, d);    check("R8 read idx9", d, 32'h0);
        bus_read(1023, d); check("R8 read idx1023", d, 32'h0);
        bus_write(0, 32'hFFFF_FFFF);
        bus_write(1, 32'hFFFF_FFFF);
        bus_write(6, 32'hFFFF_FFFF);
        bus_write(7, 32'hFFFF_FFFF);
        bus_write(1023, 32'hFFFF_FFFF);
        check("R8 outputs unchanged by unmapped writes", irq_out, hold);
        bus_read(2, d); check("R8 enable unchanged", d, 32'h0000_0005);
        bus_read(8, d); check("R8 bypass unchanged", d, 32'h0080_0000);

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        irq_in = 32'h0;
        @(negedge clk);
        check("R1 outputs after second reset", irq_out, 32'h0);
        bus_read(2, d); check("R1 enable after second reset", d, 32'h0);
        bus_read(8, d); check("R1 bypass after second reset", d, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule